// File: doc/BRIEF.md
# Byte-Lane DRAM Controller for an Asynchronous 32-bit Bus

This block sits between a 32-bit processor bus that uses an address-strobe and acknowledge handshake and a DRAM array built from four byte-wide modules, one per byte lane. When the processor starts a cycle, the block puts the row half of the address on a shared multiplexed address bus and pulls the row strobes low. It then switches the bus to the column half and strobes only the lanes that the transfer size and the two low address bits select. It answers with an acknowledge once the data is valid. It also drives the write enable, and it drives the enable and direction of the external data transceivers.

After reset the block stays quiet for a programmable power-up delay. At the default parameters this delay is 100 us at 125 MHz. The block then performs a fixed number of column-before-row refresh cycles, and only after that does it accept processor cycles. In normal operation a timer requests one refresh per programmable interval. A refresh that comes due during a processor cycle waits for that cycle to end, and a processor cycle that arrives during a refresh waits for the refresh to finish.

The processor bus has no valid/ready stream. Back-pressure takes the form of a delayed acknowledge. The processor holds the address strobe low, and its address, size and direction stable, until the acknowledge arrives. After that it raises the strobe, and the controller ends the cycle on the next clock.

Top module: `dram_ctl`

## Requirements
- R1: While reset is asserted, every RAS and CAS output, `we_n`, `ack_n` and `buf_en_n` are high.
- R2: After reset, no RAS strobe falls for at least INIT_CLKS clocks. The first INIT_REFS (8) RAS activations are refreshes, and they all come before the first processor access, even if a request is already pending.
- R3: In a refresh, all four CAS outputs go low one clock before all four RAS outputs. RAS then stays low for exactly REF_RAS_CLKS clocks, and `buf_en_n` stays high.
- R4: When RAS falls for an access, `ma` carries the row, `addr[2+MA_W +: MA_W]`. When CAS falls, `ma` carries the column, `addr[2 +: MA_W]`.
- R5: The size code (`01` byte, `10` word, `11` three bytes, `00` four bytes) covers that many bytes, starting at byte offset `addr[1:0]` and stopping at offset 3. Offset k maps to lane bit 3-k of `cas_n`. Only the covered lanes go low. For example, four bytes at offset 0 gives `cas_n`=0000, and one byte at offset 3 gives 1110.
- R6: For a write (`rw`=0), `we_n` is low at least one clock before CAS falls and stays low while CAS is low. For a read, `we_n` stays high. `buf_dir` equals `rw` (1 means toward the processor), and `buf_en_n` is low during the access.
- R7: `ack_n` falls after CAS has been low for exactly CAS_CLKS clocks. On the first clock at which `as_n` is high, `ack_n`, all RAS, all CAS and `we_n` return high.
- R8: Between two RAS activations, RAS stays high for at least max(PRE_CLKS,2) clocks.
- R9: After initialization, refreshes occur once per REF_INTERVAL clocks, to within one refresh over any long window. No refresh starts while a processor cycle holds RAS low.
- R10: A cycle with `as_n` low but `cs` low is not claimed. No RAS or CAS falls for it, and `ack_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Processor address strobe, active low |
| cs | input | 1 | Chip select decoded from upper address bits |
| rw | input | 1 | 1 = read, 0 = write |
| siz | input | 2 | Transfer size code |
| addr | input | 2*MA_W+2 | Byte address within the array |
| ack_n | output | 1 | Cycle acknowledge, active low |
| ma | output | MA_W | Multiplexed row/column address |
| ras_n | output | 4 | Row strobes, one per lane |
| cas_n | output | 4 | Column strobes, one per lane (bit 3 = offset 0) |
| we_n | output | 1 | DRAM write enable, active low |
| buf_en_n | output | 1 | Data transceiver enable, active low |
| buf_dir | output | 1 | Data transceiver direction, 1 = toward processor |

## Verification
The risky coincidence is a refresh tick that lands in the same clock as a processor request reaching the idle sequencer, or in the middle of an access. The bench provokes this with many random accesses separated by random idle gaps, over a span that covers many refresh intervals, so ticks fall at every phase of an access. A monitor classifies every RAS fall as either a refresh (CAS already low) or an access. It checks that no refresh ever interrupts an access, that every access still returns the right lanes, addresses and acknowledge timing, and that the number of refreshes matches the elapsed time to within one.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
  localparam int LANES = 4;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_IDLE,
    ST_ROW,
    ST_RCD,
    ST_COL,
    ST_CAS,
    ST_ACK,
    ST_RCAS,
    ST_RRAS,
    ST_PRE
  } seq_state_t;

  localparam logic [1:0] SZ_FOUR  = 2'b00;
  localparam logic [1:0] SZ_ONE   = 2'b01;
  localparam logic [1:0] SZ_TWO   = 2'b10;
  localparam logic [1:0] SZ_THREE = 2'b11;
endpackage

// File: rtl/dram_lane_dec.sv
module dram_lane_dec
  import dram_ctl_pkg::*;
(
  input  logic [1:0]       siz,
  input  logic [1:0]       off,
  output logic [LANES-1:0] lane_en
);
  logic [2:0] nbytes;
  logic [2:0] first;
  logic [2:0] past_end;

  assign nbytes   = (siz == SZ_FOUR) ? 3'd4 : {1'b0, siz};
  assign first    = {1'b0, off};
  assign past_end = first + nbytes;

  // offset k drives lane bit (LANES-1-k): big-endian lane order
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [2:0] K = 3'(k);
    assign lane_en[LANES-1-k] = (K >= first) && (K < past_end);
  end
endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int INIT_CLKS    = 12500,
  parameter int REF_INTERVAL = 1950
) (
  input  logic clk,
  input  logic rst_n,
  output logic init_done,
  output logic ref_tick
);
  localparam int IW = $clog2(INIT_CLKS + 1);
  localparam int RW = $clog2(REF_INTERVAL + 1);

  logic [IW-1:0] init_cnt;
  logic [RW-1:0] ref_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt  <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      if (init_cnt == IW'(INIT_CLKS - 1)) init_done <= 1'b1;
      else                                 init_cnt  <= init_cnt + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_tick <= 1'b0;
    end else if (init_done) begin
      if (ref_cnt == RW'(REF_INTERVAL - 1)) begin
        ref_cnt  <= '0;
        ref_tick <= 1'b1;
      end else begin
        ref_cnt  <= ref_cnt + RW'(1);
        ref_tick <= 1'b0;
      end
    end else begin
      ref_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctl_pkg::*;
#(
  parameter int MA_W         = 11,
  parameter int RCD_CLKS     = 3,
  parameter int CAS_CLKS     = 5,
  parameter int PRE_CLKS     = 4,
  parameter int REF_RAS_CLKS = 6,
  parameter int INIT_REFS    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_done,
  input  logic             ref_tick,
  input  logic             req,
  input  logic             as_n,
  input  logic             rw,
  input  logic [LANES-1:0] lane_en,
  input  logic [MA_W-1:0]  row,
  input  logic [MA_W-1:0]  col,
  output logic             ack_n,
  output logic [MA_W-1:0]  ma,
  output logic [LANES-1:0] ras_n,
  output logic [LANES-1:0] cas_n,
  output logic             we_n,
  output logic             buf_en_n,
  output logic             buf_dir
);
  localparam int PRE_EFF = (PRE_CLKS < 2) ? 2 : PRE_CLKS;
  localparam int MAXC    = (RCD_CLKS > CAS_CLKS)
                         ? ((RCD_CLKS > PRE_EFF) ? RCD_CLKS : PRE_EFF)
                         : ((CAS_CLKS > PRE_EFF) ? CAS_CLKS : PRE_EFF);
  localparam int MAXA    = (MAXC > REF_RAS_CLKS) ? MAXC : REF_RAS_CLKS;
  localparam int CW      = $clog2(MAXA + 1);
  localparam int NW      = $clog2(INIT_REFS + 1);
  localparam logic [LANES-1:0] ALL_HI = '1;

  seq_state_t       st;
  logic [CW-1:0]    cnt;
  logic [NW-1:0]    init_left;
  logic             pend;
  logic [LANES-1:0] lane_q;
  logic [MA_W-1:0]  col_q;
  logic             rw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_INIT;
      cnt       <= '0;
      init_left <= NW'(INIT_REFS);
      pend      <= 1'b0;
      lane_q    <= '0;
      col_q     <= '0;
      rw_q      <= 1'b1;
      ack_n     <= 1'b1;
      ma        <= '0;
      ras_n     <= ALL_HI;
      cas_n     <= ALL_HI;
      we_n      <= 1'b1;
      buf_en_n  <= 1'b1;
      buf_dir   <= 1'b1;
    end else begin
      pend <= pend | ref_tick;
      unique case (st)
        ST_INIT: if (init_done) st <= ST_IDLE;
        ST_IDLE: begin
          if (init_left != '0 || pend) begin
            // refresh has priority over a waiting processor cycle
            cas_n <= '0;
            st    <= ST_RCAS;
            if (init_left != '0) init_left <= init_left - NW'(1);
            else                 pend      <= ref_tick;
          end else if (req) begin
            ma       <= row;
            lane_q   <= lane_en;
            col_q    <= col;
            rw_q     <= rw;
            buf_dir  <= rw;
            buf_en_n <= 1'b0;
            st       <= ST_ROW;
          end
        end
        ST_ROW: begin
          ras_n <= '0;
          cnt   <= CW'(RCD_CLKS - 1);
          st    <= ST_RCD;
        end
        ST_RCD: begin
          if (cnt == '0) begin
            ma   <= col_q;
            we_n <= rw_q;
            st   <= ST_COL;
          end else cnt <= cnt - CW'(1);
        end
        ST_COL: begin
          cas_n <= ~lane_q;
          cnt   <= CW'(CAS_CLKS - 1);
          st    <= ST_CAS;
        end
        ST_CAS: begin
          if (cnt == '0) begin
            ack_n <= 1'b0;
            st    <= ST_ACK;
          end else cnt <= cnt - CW'(1);
        end
        ST_ACK: begin
          if (as_n) begin
            ack_n    <= 1'b1;
            ras_n    <= ALL_HI;
            cas_n    <= ALL_HI;
            we_n     <= 1'b1;
            buf_en_n <= 1'b1;
            buf_dir  <= 1'b1;
            cnt      <= CW'(PRE_EFF - 1);
            st       <= ST_PRE;
          end
        end
        ST_RCAS: begin
          ras_n <= '0;
          cnt   <= CW'(REF_RAS_CLKS - 1);
          st    <= ST_RRAS;
        end
        ST_RRAS: begin
          if (cnt == '0) begin
            ras_n <= ALL_HI;
            cas_n <= ALL_HI;
            cnt   <= CW'(PRE_EFF - 1);
            st    <= ST_PRE;
          end else cnt <= cnt - CW'(1);
        end
        ST_PRE: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - CW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
  import dram_ctl_pkg::*;
#(
  parameter int MA_W         = 11,
  parameter int INIT_CLKS    = 12500,
  parameter int REF_INTERVAL = 1950,
  parameter int RCD_CLKS     = 3,
  parameter int CAS_CLKS     = 5,
  parameter int PRE_CLKS     = 4,
  parameter int REF_RAS_CLKS = 6,
  parameter int INIT_REFS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic              cs,
  input  logic              rw,
  input  logic [1:0]        siz,
  input  logic [2*MA_W+1:0] addr,
  output logic              ack_n,
  output logic [MA_W-1:0]   ma,
  output logic [3:0]        ras_n,
  output logic [3:0]        cas_n,
  output logic              we_n,
  output logic              buf_en_n,
  output logic              buf_dir
);
  logic             init_done;
  logic             ref_tick;
  logic [LANES-1:0] lane_en;

  dram_ref_timer #(
    .INIT_CLKS   (INIT_CLKS),
    .REF_INTERVAL(REF_INTERVAL)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_done(init_done),
    .ref_tick (ref_tick)
  );

  dram_lane_dec u_lanes (
    .siz    (siz),
    .off    (addr[1:0]),
    .lane_en(lane_en)
  );

  dram_seq #(
    .MA_W        (MA_W),
    .RCD_CLKS    (RCD_CLKS),
    .CAS_CLKS    (CAS_CLKS),
    .PRE_CLKS    (PRE_CLKS),
    .REF_RAS_CLKS(REF_RAS_CLKS),
    .INIT_REFS   (INIT_REFS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_done(init_done),
    .ref_tick (ref_tick),
    .req      (~as_n & cs),
    .as_n     (as_n),
    .rw       (rw),
    .lane_en  (lane_en),
    .row      (addr[2+MA_W +: MA_W]),
    .col      (addr[2 +: MA_W]),
    .ack_n    (ack_n),
    .ma       (ma),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .buf_en_n (buf_en_n),
    .buf_dir  (buf_dir)
  );
endmodule

// File: rtl/dram_ctl_chk.sv
module dram_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       as_n,
  input logic       ack_n,
  input logic [3:0] ras_n,
  input logic [3:0] cas_n,
  input logic       we_n,
  input logic       buf_en_n
);
  // R3: all CAS low while RAS high is the refresh lead-in; RAS must follow
  a_r3_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == 4'hF && cas_n == 4'h0) |=> (ras_n == 4'h0));

  // R3: the data transceivers stay off during a refresh
  a_r3_ref_buf_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == 4'hF && cas_n == 4'h0) |-> buf_en_n);

  // R6: write enable is settled before CAS falls in an access
  a_r6_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != 4'hF && $past(cas_n) == 4'hF && ras_n == 4'h0) |-> (we_n == $past(we_n)));

  // R7: acknowledge only while the row and some column strobe are active
  a_r7_ack_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> (ras_n == 4'h0 && cas_n != 4'hF && !buf_en_n));

  // R7: strobe release ends the cycle on the next clock
  a_r7_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && as_n) |=> (ack_n && ras_n == 4'hF && cas_n == 4'hF && we_n));

  // R8: once RAS rises it stays high for at least one more clock
  a_r8_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |=> ras_n[0]);
endmodule

bind dram_ctl dram_ctl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .as_n    (as_n),
  .ack_n   (ack_n),
  .ras_n   (ras_n),
  .cas_n   (cas_n),
  .we_n    (we_n),
  .buf_en_n(buf_en_n)
);

// File: tb/dram_ctl_tb.sv
module dram_ctl_tb;
  localparam int MA_W     = 10;
  localparam int INIT_C   = 400;
  localparam int REF_I    = 250;
  localparam int RCD      = 2;
  localparam int CASC     = 3;
  localparam int PRE      = 3;
  localparam int REFRAS   = 3;
  localparam int NREF     = 8;
  localparam int AW       = 2*MA_W+2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            as_n = 1'b1;
  logic            cs = 1'b0;
  logic            rw = 1'b1;
  logic [1:0]      siz = 2'b00;
  logic [AW-1:0]   addr = '0;
  logic            ack_n;
  logic [MA_W-1:0] ma;
  logic [3:0]      ras_n, cas_n;
  logic            we_n, buf_en_n, buf_dir;

  int checks = 0, fails = 0;
  int cyc = 0;
  int ref_count = 0, acc_count = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_ctl #(
    .MA_W(MA_W), .INIT_CLKS(INIT_C), .REF_INTERVAL(REF_I), .RCD_CLKS(RCD),
    .CAS_CLKS(CASC), .PRE_CLKS(PRE), .REF_RAS_CLKS(REFRAS), .INIT_REFS(NREF)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .cs(cs), .rw(rw), .siz(siz),
    .addr(addr), .ack_n(ack_n), .ma(ma), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .buf_en_n(buf_en_n), .buf_dir(buf_dir)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_lanes(input logic [1:0] sz, input logic [1:0] off);
    int n = (sz == 2'b00) ? 4 : int'(sz);
    logic [3:0] m = '0;
    for (int k = 0; k < 4; k++)
      if (k >= int'(off) && k < int'(off) + n) m[3-k] = 1'b1;
    return m;
  endfunction

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor: classifies every RAS fall, checks refresh shape and precharge
  logic [3:0] p_ras = 4'hF, p_cas = 4'hF;
  int hi_len = 0, lo_len = 0;
  bit in_ref = 1'b0, seen_rise = 1'b0, first_ev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ras_n != 4'hF && p_ras == 4'hF) begin
        if (first_ev) begin
          chk(cyc >= INIT_C, "R2 first RAS after init delay", cyc, INIT_C);
          first_ev = 1'b0;
        end
        if (seen_rise) chk(hi_len >= PRE, "R8 precharge", hi_len, PRE);
        if (cas_n == 4'h0) begin
          ref_count++;
          chk(p_cas == 4'h0 && ras_n == 4'h0, "R3 CAS before RAS", p_cas, 0);
          chk(buf_en_n == 1'b1, "R3 buffer off in refresh", buf_en_n, 1);
          in_ref = 1'b1;
        end else begin
          if (acc_count == 0)
            chk(ref_count == NREF, "R2 init refreshes before access", ref_count, NREF);
          acc_count++;
          in_ref = 1'b0;
        end
        lo_len = 0;
      end
      if (ras_n == 4'hF && p_ras != 4'hF) begin
        if (in_ref) chk(lo_len == REFRAS, "R3 refresh RAS width", lo_len, REFRAS);
        seen_rise = 1'b1;
        hi_len = 0;
      end
      if (ras_n == 4'hF) hi_len++;
      else lo_len++;
      p_ras = ras_n;
      p_cas = cas_n;
    end
  end

  task automatic access(input logic [AW-1:0] a, input logic [1:0] sz, input logic r);
    logic [3:0] pr;
    logic pw;
    int n;
    @(negedge clk);
    addr = a; siz = sz; rw = r; cs = 1'b1; as_n = 1'b0;
    pr = ras_n;
    forever begin
      @(negedge clk);
      if (ras_n != 4'hF && pr == 4'hF && cas_n == 4'hF) break;
      pr = ras_n;
    end
    chk(ma == a[2+MA_W +: MA_W], "R4 row address", int'(ma), int'(a[2+MA_W +: MA_W]));
    pw = we_n;
    forever begin
      @(negedge clk);
      if (cas_n != 4'hF) break;
      pw = we_n;
    end
    chk(ma == a[2 +: MA_W], "R4 column address", int'(ma), int'(a[2 +: MA_W]));
    chk(cas_n == ~exp_lanes(sz, a[1:0]), "R5 lane select", int'(cas_n), int'(~exp_lanes(sz, a[1:0])));
    chk(we_n == r && pw == r, "R6 write enable", int'({pw, we_n}), int'({r, r}));
    chk(buf_en_n == 1'b0 && buf_dir == r, "R6 buffer control", int'({buf_en_n, buf_dir}), int'({1'b0, r}));
    n = 0;
    while (ack_n) begin
      n++;
      @(negedge clk);
      if (n > 50) break;
    end
    chk(n == CASC, "R7 access time", n, CASC);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    as_n = 1'b1;
    @(negedge clk);
    chk(ack_n && ras_n == 4'hF && cas_n == 4'hF && we_n,
        "R7 release", int'({ack_n, ras_n, cas_n, we_n}), 10'h3FF);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int t0, r0, dr, er, a0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(ras_n == 4'hF && cas_n == 4'hF && we_n && ack_n && buf_en_n,
        "R1 reset state", int'({ras_n, cas_n, we_n, ack_n, buf_en_n}), 11'h7FF);
    rst_n = 1'b1;
    // R2: request pending from the start must wait for init refreshes
    access({$urandom} % (1 << AW), 2'b00, 1'b1);
    // R5/R6: every size/offset pair, read and write
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        for (int w = 0; w < 2; w++)
          access({AW'($urandom) & ~AW'(3)} | AW'(o), 2'(s), 1'(w));
    // R10: unselected cycle is ignored
    a0 = acc_count;
    @(negedge clk);
    cs = 1'b0; as_n = 1'b0;
    begin
      bit acked = 1'b0;
      repeat (40) begin
        @(negedge clk);
        if (!ack_n) acked = 1'b1;
      end
      chk(!acked && acc_count == a0, "R10 unselected ignored", acc_count - a0, 0);
    end
    as_n = 1'b1;
    // R9: random traffic over many refresh intervals
    t0 = cyc; r0 = ref_count;
    for (int i = 0; i < 160; i++) begin
      access(AW'($urandom), 2'($urandom), 1'($urandom));
      repeat ($urandom_range(0, 20)) @(negedge clk);
    end
    dr = ref_count - r0;
    er = (cyc - t0) / REF_I;
    chk(dr >= er - 1 && dr <= er + 1, "R9 refresh rate", dr, er);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule